// File: doc/BRIEF.md
# Spare Stream Status Extractor

This block sits on the byte stream that carries a page's spare area back from an error-correction engine. The engine follows each chunk's spare bytes with four status bytes. The extractor removes those status bytes, so the downstream consumer receives the spare area as one linear run of `chunks * spare_len` bytes. The block also decodes the first status byte of every chunk and builds page-level error statistics from it.

A page begins with a one-cycle `page_start` pulse. That pulse samples the chunk spare length and the chunk count, clears the statistics and rewinds the byte position. Both data ports use valid/ready handshakes. A spare beat is accepted only when the output can take it, so `in_ready` follows `out_ready` on those beats. A status beat never reaches the output, and it is accepted whatever the state of `out_ready`. When the last status byte of the last chunk is accepted, `done` pulses for one cycle. The statistics are valid at that point and hold until the next `page_start`.

Top module: `spare_stat_strip`

## Requirements
- R1: The output carries exactly the spare bytes of every chunk, in stream order, for a total of chunks * spare_len bytes. None of the four status bytes that follow each chunk appears on the output.
- R2: On a spare-byte position, `out_valid` equals `in_valid`, `out_data` equals `in_data`, and `in_ready` equals `out_ready`. A stalled output therefore holds the input.
- R3: On a status-byte position, `in_ready` is 1 even when `out_ready` is 0, and `out_valid` is 0.
- R4: The first status byte of each chunk is decoded. The code 0x00 (clean) and the code 0xFF (erased) change neither the corrected statistics nor the failure statistics.
- R5: The code 0xFE, or any code above 0x28, marks the chunk as uncorrectable. It increments `fail_cnt` and sets `page_fail`.
- R6: Any code from 0x01 to 0x28 is a corrected bit count. It is added to `sum_corr`, and `max_corr` takes the larger of its current value and this code.
- R7: The second, third and fourth status bytes of a chunk are consumed without being decoded, whatever their values.
- R8: `done` is high for exactly one cycle, in the cycle after the last status byte of the last chunk is accepted. After that, `in_ready` stays 0 and the statistics hold until the next `page_start`.
- R9: In a cycle where `page_start` is high, `in_ready` and `out_valid` are 0. In the following cycle all statistics read zero, the sampled configuration is in force, and the position restarts at the first byte of chunk 0. This also aborts a page that is still in progress.
- R10: After reset, `in_ready`, `out_valid` and `done` are 0 and every statistic reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| page_start | input | 1 | One-cycle pulse that begins a page and samples the configuration |
| cfg_spare_len | input | LEN_W | Spare bytes per chunk (at least 1) |
| cfg_chunks | input | CNT_W | Chunks per page (at least 1) |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted when high together with in_valid |
| in_data | input | 8 | Input byte (spare or status) |
| out_valid | output | 1 | Output spare byte valid |
| out_ready | input | 1 | Downstream can take a byte |
| out_data | output | 8 | Output spare byte |
| done | output | 1 | One-cycle end-of-page pulse |
| max_corr | output | 8 | Largest corrected count among the page's chunks |
| sum_corr | output | CNT_W+8 | Total corrected bits in the page |
| fail_cnt | output | CNT_W | Number of uncorrectable chunks |
| page_fail | output | 1 | At least one chunk was uncorrectable |

## Verification
The properties assume that `page_start` arrives as a pulse and that the configuration it samples has a spare length and a chunk count of at least one. They also assume that no beat is offered before the first `page_start`. The bounds on `max_corr` and `sum_corr` then follow from the decode rules alone. The directed stimulus starts every page with a single-cycle pulse and uses only non-zero lengths and counts. It does raise `in_valid` during the start cycle and after `done`, to show that those beats are refused. It also holds `out_ready` low across whole status runs, so that status beats are accepted under full back-pressure.

// File: rtl/sss_pkg.sv
package sss_pkg;
  localparam int STAT_BYTES = 4;
  localparam logic [7:0] ST_CLEAN    = 8'h00;
  localparam logic [7:0] ST_ERASED   = 8'hFF;
  localparam logic [7:0] ST_UNCORR   = 8'hFE;
  localparam logic [7:0] ST_CORR_MAX = 8'h28;

  typedef enum logic [1:0] {
    CLS_CLEAN  = 2'd0,
    CLS_ERASED = 2'd1,
    CLS_CORR   = 2'd2,
    CLS_FAIL   = 2'd3
  } stat_cls_e;
endpackage

// File: rtl/sss_classify.sv
module sss_classify
  import sss_pkg::*;
(
  input  logic [7:0] code,
  output stat_cls_e  cls,
  output logic [7:0] nbits
);
  always_comb begin
    if (code == ST_CLEAN)                              cls = CLS_CLEAN;
    else if (code == ST_ERASED)                        cls = CLS_ERASED;
    else if (code == ST_UNCORR || code > ST_CORR_MAX)  cls = CLS_FAIL;
    else                                               cls = CLS_CORR;
    nbits = (cls == CLS_CORR) ? code : 8'd0;
  end
endmodule

// File: rtl/sss_track.sv
module sss_track
  import sss_pkg::*;
#(
  parameter int LEN_W = 8,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic [CNT_W-1:0] cfg_cnt,
  input  logic             beat,
  output logic             active,
  output logic             at_spare,
  output logic             at_first,
  output logic             page_end
);
  localparam int POS_W = LEN_W + 1;

  logic [LEN_W-1:0] len_q;
  logic [CNT_W-1:0] cnt_q;
  logic [POS_W-1:0] pos;
  logic [CNT_W-1:0] chunk;
  logic             chunk_end;
  logic             last_chunk;

  assign at_spare   = pos < POS_W'(len_q);
  assign at_first   = pos == POS_W'(len_q);
  assign chunk_end  = pos == POS_W'(len_q) + POS_W'(STAT_BYTES - 1);
  assign last_chunk = chunk == cnt_q - CNT_W'(1);
  assign page_end   = beat & chunk_end & last_chunk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      len_q  <= '0;
      cnt_q  <= '0;
      pos    <= '0;
      chunk  <= '0;
    end else if (start) begin
      active <= 1'b1;
      len_q  <= cfg_len;
      cnt_q  <= cfg_cnt;
      pos    <= '0;
      chunk  <= '0;
    end else if (beat) begin
      if (chunk_end) begin
        pos <= '0;
        if (last_chunk) active <= 1'b0;
        else            chunk  <= chunk + CNT_W'(1);
      end else begin
        pos <= pos + POS_W'(1);
      end
    end
  end
endmodule

// File: rtl/sss_stats.sv
module sss_stats
  import sss_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int SUM_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             upd,
  input  stat_cls_e        cls,
  input  logic [7:0]       nbits,
  output logic [7:0]       max_corr,
  output logic [SUM_W-1:0] sum_corr,
  output logic [CNT_W-1:0] fail_cnt,
  output logic             page_fail
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      max_corr  <= '0;
      sum_corr  <= '0;
      fail_cnt  <= '0;
      page_fail <= 1'b0;
    end else if (clear) begin
      max_corr  <= '0;
      sum_corr  <= '0;
      fail_cnt  <= '0;
      page_fail <= 1'b0;
    end else if (upd) begin
      if (cls == CLS_FAIL) begin
        fail_cnt  <= fail_cnt + CNT_W'(1);
        page_fail <= 1'b1;
      end
      if (cls == CLS_CORR) begin
        sum_corr <= sum_corr + SUM_W'(nbits);
        if (nbits > max_corr) max_corr <= nbits;
      end
    end
  end
endmodule

// File: rtl/spare_stat_strip.sv
module spare_stat_strip
  import sss_pkg::*;
#(
  parameter int LEN_W = 8,
  parameter int CNT_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               page_start,
  input  logic [LEN_W-1:0]   cfg_spare_len,
  input  logic [CNT_W-1:0]   cfg_chunks,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [7:0]         in_data,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [7:0]         out_data,
  output logic               done,
  output logic [7:0]         max_corr,
  output logic [CNT_W+7:0]   sum_corr,
  output logic [CNT_W-1:0]   fail_cnt,
  output logic               page_fail
);
  localparam int SUM_W = CNT_W + 8;

  logic      active, at_spare, at_first, page_end;
  logic      beat, stat_upd, open;
  stat_cls_e cls;
  logic [7:0] nbits;

  sss_track #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (page_start),
    .cfg_len  (cfg_spare_len),
    .cfg_cnt  (cfg_chunks),
    .beat     (beat),
    .active   (active),
    .at_spare (at_spare),
    .at_first (at_first),
    .page_end (page_end)
  );

  // Status beats never wait on the output side.
  assign open      = active & ~page_start;
  assign in_ready  = open & (at_spare ? out_ready : 1'b1);
  assign out_valid = open & at_spare & in_valid;
  assign out_data  = in_data;
  assign beat      = in_valid & in_ready;
  assign stat_upd  = beat & at_first;

  sss_classify u_cls (
    .code  (in_data),
    .cls   (cls),
    .nbits (nbits)
  );

  sss_stats #(.CNT_W(CNT_W), .SUM_W(SUM_W)) u_stats (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (page_start),
    .upd       (stat_upd),
    .cls       (cls),
    .nbits     (nbits),
    .max_corr  (max_corr),
    .sum_corr  (sum_corr),
    .fail_cnt  (fail_cnt),
    .page_fail (page_fail)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done <= 1'b0;
    else        done <= page_end;
  end
endmodule

// File: rtl/sss_chk.sv
module sss_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             page_start,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic             done,
  input logic             stat_upd,
  input logic [7:0]       max_corr,
  input logic [CNT_W+7:0] sum_corr,
  input logic [CNT_W-1:0] fail_cnt,
  input logic             page_fail
);
  localparam int SUM_W = CNT_W + 8;

  p_out_needs_in_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> in_valid);
  p_stall_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
  p_fail_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    page_fail == (fail_cnt != '0));
  p_max_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (max_corr <= 8'h28) && (sum_corr >= SUM_W'(max_corr)));
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!in_ready && !out_valid));
  p_stats_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!page_start && !stat_upd) |=> ($stable(sum_corr) && $stable(fail_cnt) && $stable(max_corr)));
  p_start_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
    page_start |-> (!in_ready && !out_valid));
  p_start_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    page_start |=> (sum_corr == '0 && fail_cnt == '0 && max_corr == 8'd0 && !page_fail));
endmodule

bind spare_stat_strip sss_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .page_start (page_start),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .done       (done),
  .stat_upd   (stat_upd),
  .max_corr   (max_corr),
  .sum_corr   (sum_corr),
  .fail_cnt   (fail_cnt),
  .page_fail  (page_fail)
);

// File: tb/sim_spare_stat_strip.sv
`timescale 1ns/1ps
module sim_spare_stat_strip;
  localparam int LEN_W = 8;
  localparam int CNT_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic page_start = 1'b0;
  logic [LEN_W-1:0] cfg_spare_len = '0;
  logic [CNT_W-1:0] cfg_chunks = '0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [7:0] in_data = 8'h00;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [7:0] out_data;
  logic done;
  logic [7:0] max_corr;
  logic [CNT_W+7:0] sum_corr;
  logic [CNT_W-1:0] fail_cnt;
  logic page_fail;

  always #2 clk = ~clk;

  spare_stat_strip #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .page_start(page_start),
    .cfg_spare_len(cfg_spare_len), .cfg_chunks(cfg_chunks),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .done(done), .max_corr(max_corr), .sum_corr(sum_corr),
    .fail_cnt(fail_cnt), .page_fail(page_fail)
  );

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  logic [7:0] strm [0:1023];
  logic [7:0] expq [0:1023];
  logic [7:0] outq [0:1023];
  logic [7:0] st   [0:15];
  int expn, outn;
  int exp_max, exp_sum, exp_fail;
  int r2_bad, r3_bad, r8_bad;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Build the stream and the expectations from the requirements.
  task automatic build(input int len, input int chunks, input int seed);
    int p = 0;
    expn = 0; exp_max = 0; exp_sum = 0; exp_fail = 0;
    for (int k = 0; k < chunks; k++) begin
      for (int i = 0; i < len; i++) begin
        strm[p] = 8'(seed + k * 29 + i * 7);
        expq[expn] = strm[p];
        p++; expn++;
      end
      strm[p] = st[k];
      strm[p+1] = 8'hFE;        // decoy bytes that would disturb stats (R7)
      strm[p+2] = 8'h27;
      strm[p+3] = 8'h99;
      p += 4;
      if (st[k] == 8'h00 || st[k] == 8'hFF) begin
      end else if (st[k] == 8'hFE || st[k] > 8'h28) begin
        exp_fail++;
      end else begin
        exp_sum += int'(st[k]);
        if (int'(st[k]) > exp_max) exp_max = int'(st[k]);
      end
    end
  endtask

  task automatic start_page(input int len, input int chunks);
    @(posedge clk); #1;
    page_start = 1'b1; cfg_spare_len = LEN_W'(len); cfg_chunks = CNT_W'(chunks);
    in_valid = 1'b1; in_data = 8'hAA; out_ready = 1'b1;
    #2;
    chk(!in_ready && !out_valid, "R9", "beat refused in start cycle", int'(in_ready), 0);
    @(posedge clk); #1;
    page_start = 1'b0; in_valid = 1'b0;
    cfg_spare_len = LEN_W'(len + 3); cfg_chunks = CNT_W'(chunks + 1); // must be ignored
    #2;
    chk(sum_corr == 0 && fail_cnt == 0 && max_corr == 0 && !page_fail,
        "R9", "stats cleared after start", int'(sum_corr) + int'(fail_cnt), 0);
  endtask

  // mode 0: full rate; mode 1: input gaps and output stalls, status runs fully stalled.
  task automatic run_page(input int len, input int chunks, input int mode,
                          input int stop_after);
    int idx = 0;
    int total = chunks * (len + 4);
    int cyc = 0;
    int pos;
    outn = 0; r2_bad = 0; r3_bad = 0; r8_bad = 0;
    while (idx < total && idx != stop_after && cyc < 5000) begin
      @(posedge clk); #1;
      pos = idx % (len + 4);
      in_data = strm[idx];
      in_valid = (mode == 0) ? 1'b1 : (cyc % 3 != 2);
      out_ready = (mode == 0) ? 1'b1 : ((pos < len) ? (cyc % 4 != 1) : 1'b0);
      #2;
      if (done) r8_bad++;
      if (in_valid && pos < len) begin
        if (!out_valid || out_data != in_data || in_ready != out_ready) r2_bad++;
      end
      if (in_valid && pos >= len) begin
        if (!in_ready || out_valid) r3_bad++;
      end
      if (out_valid && out_ready) begin
        outq[outn] = out_data; outn++;
      end
      if (in_valid && in_ready) idx++;
      cyc++;
    end
    chk(r2_bad == 0, "R2", "spare beats mirror the handshake", r2_bad, 0);
    chk(r3_bad == 0, "R3", "status beats accepted without output", r3_bad, 0);
    if (idx == total) begin
      chk(r8_bad == 0, "R8", "no early done", r8_bad, 0);
      @(posedge clk); #1; in_valid = 1'b0; #2;
      chk(done == 1'b1, "R8", "done after last status byte", int'(done), 1);
    end else begin
      @(posedge clk); #1; in_valid = 1'b0;
    end
  endtask

  task automatic check_after_done();
    int s0 = int'(sum_corr);
    @(posedge clk); #1; in_valid = 1'b1; in_data = 8'h5A; out_ready = 1'b1; #2;
    chk(!done, "R8", "done lasts one cycle", int'(done), 0);
    chk(!in_ready && !out_valid, "R8", "input closed after page", int'(in_ready), 0);
    @(posedge clk); #1; in_valid = 1'b0; #2;
    chk(int'(sum_corr) == s0, "R8", "stats held after page", int'(sum_corr), s0);
  endtask

  task automatic check_output(input string req);
    int bad = 0;
    for (int i = 0; i < expn && i < outn; i++) if (outq[i] != expq[i]) bad++;
    chk(outn == expn, req, "output byte count", outn, expn);
    chk(bad == 0, req, "output byte content", bad, 0);
  endtask

  task automatic t_reset();
    #1; in_valid = 1'b1; out_ready = 1'b1;
    repeat (3) @(posedge clk);
    #1; rst_n = 1'b1; #2;
    chk(!in_ready && !out_valid && !done, "R10", "handshake idle after reset", int'(in_ready), 0);
    chk(sum_corr == 0 && max_corr == 0 && fail_cnt == 0 && !page_fail,
        "R10", "stats zero after reset", int'(sum_corr), 0);
    @(posedge clk); #1; in_valid = 1'b0;
  endtask

  task automatic t_basic();
    st[0] = 8'h00; st[1] = 8'h05; st[2] = 8'hFF;
    build(6, 3, 17);
    start_page(6, 3);
    run_page(6, 3, 0, -1);
    check_output("R1");
    chk(int'(max_corr) == exp_max, "R6", "max corrected", int'(max_corr), exp_max);
    chk(int'(sum_corr) == exp_sum, "R4", "clean/erased add nothing", int'(sum_corr), exp_sum);
    chk(fail_cnt == 0 && !page_fail, "R7", "decoy status bytes not decoded", int'(fail_cnt), 0);
    check_after_done();
  endtask

  task automatic t_backpressure();
    st[0] = 8'h28; st[1] = 8'h03; st[2] = 8'h10; st[3] = 8'h00;
    build(5, 4, 90);
    start_page(5, 4);
    run_page(5, 4, 1, -1);
    check_output("R1");
    chk(int'(sum_corr) == exp_sum, "R6", "sum under back-pressure", int'(sum_corr), exp_sum);
    chk(int'(max_corr) == exp_max, "R6", "max at limit code 0x28", int'(max_corr), exp_max);
    chk(fail_cnt == 0, "R6", "0x28 is correctable", int'(fail_cnt), 0);
  endtask

  task automatic t_fail();
    st[0] = 8'hFE; st[1] = 8'h29; st[2] = 8'h01; st[3] = 8'hFF;
    build(3, 4, 200);
    start_page(3, 4);
    run_page(3, 4, 0, -1);
    check_output("R1");
    chk(int'(fail_cnt) == exp_fail, "R5", "failed chunk count", int'(fail_cnt), exp_fail);
    chk(page_fail == 1'b1, "R5", "page fail flag", int'(page_fail), 1);
    chk(int'(sum_corr) == exp_sum && int'(max_corr) == exp_max, "R6",
        "correction beside failures", int'(sum_corr), exp_sum);
  endtask

  task automatic t_abort();
    st[0] = 8'hFE; st[1] = 8'h11; st[2] = 8'h22;
    build(5, 3, 33);
    start_page(5, 3);
    run_page(5, 3, 0, 12);        // chunk 0 done (one failure), mid chunk 1
    st[0] = 8'h02; st[1] = 8'h07;
    build(4, 2, 140);
    start_page(4, 2);
    run_page(4, 2, 0, -1);
    check_output("R9");
    chk(int'(sum_corr) == exp_sum && fail_cnt == 0, "R9", "only restarted page counted",
        int'(sum_corr), exp_sum);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_backpressure();
    t_fail();
    t_abort();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #800000;
    if (!finished) begin
      n_err++; n_chk++;
      $display("FAIL R8 watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule